// File: doc/BRIEF.md
# Sub-pixel edge generator for CCD readout timing

This block builds the fast per-pixel waveforms that drive and sample a CCD output stage. It runs from a clock at 48 times the pixel rate. A phase counter steps through 48 positions per pixel, and every waveform edge is placed on one of those positions. The signals it produces are:

- a reset-gate pulse;
- a complementary pair of horizontal transfer clocks;
- two single-position sampling strobes (reference level and data level);
- a data-output clock;
- a latch that captures a 10-bit pixel word at a programmed position.

Software-visible timing lives in two configuration words written through a plain address/data/enable port. The sampling word sits at address 2 and the edge word at address 3. Writes land in a shadow copy, and the copy is transferred to the live settings only at a pixel boundary, so a waveform never changes shape part-way through a pixel. The pixel data path has no handshake. A new word is presented on every clock and is sampled once per pixel. Nothing can stall the sensor readout, so there is no back-pressure.

Top module: `pix_edge_gen`

## Requirements
- R1: The phase counter resets to position 0, advances by one on every clock, and returns to 0 after position 47, so one pixel lasts 48 clocks.
- R2: A 6-bit location field is decoded as quadrant (bits 5:4) times 12 plus offset (bits 3:0). An offset above 11 counts as 11.
- R3: `rgate` is high from position 0 up to, but not including, the decoded fall location. A fall location of 0 keeps it low for the whole pixel.
- R4: `hclk_p` is high for 24 consecutive positions beginning at its decoded rise location. The window wraps modulo 48 into the next pixel.
- R5: `hclk_n` is always the inverse of `hclk_p`.
- R6: `smp_ref` and `smp_dat` are each high for exactly the one position equal to their decoded location.
- R7: `dclk` is high for 24 consecutive positions beginning at its decoded phase, wrapping modulo 48.
- R8: `pix_din` is captured into `pix_dout` at the end of the position equal to the decoded output phase. The new word appears from the following position onward.
- R9: Address 2 carries the reference-strobe location in bits 5:0, the data-strobe location in 11:6, the data-clock phase in 17:12 and the output phase in 23:18. Address 3 carries the reset-gate fall location in bits 5:0 and the transfer-clock rise location in 11:6. A write takes effect at the next position 0. A write issued while the counter is at 47 takes effect one pixel later.
- R10: Writes to any other address, and data bits above the fields of the addressed word, change no output.
- R11: After reset all fields are 0. In the first position, `rgate` is 0, `hclk_p` is 1, `hclk_n` is 0, both strobes are 1, `dclk` is 1 and `pix_dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, 48 per pixel |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 8 | Configuration word address |
| cfg_wdata | input | 24 | Configuration write data |
| pix_din | input | 10 | Pixel word to be latched |
| rgate | output | 1 | Reset-gate pulse |
| hclk_p | output | 1 | Horizontal transfer clock |
| hclk_n | output | 1 | Inverse horizontal transfer clock |
| smp_ref | output | 1 | Reference-level sample strobe |
| smp_dat | output | 1 | Data-level sample strobe |
| dclk | output | 1 | Data-output clock |
| pix_dout | output | 10 | Latched pixel word |

## Verification
Every waveform output is registered from the next counter value. The level shown while the counter holds position p is therefore the level defined for p, with no lag. The bench keeps its own position counter from reset and compares each output on the falling edge against that position. The latched word is due one position after the output phase, so it is compared against the word presented at that phase, in the same pixel or the previous one. Configuration changes are expected only from the first position 0 after the write is sampled. For that reason, the sweeps that follow a write begin at that boundary, and the first sweep after a change leaves out the latched-word check.

// File: rtl/pix_edge_pkg.sv
package pix_edge_pkg;
  localparam int unsigned PIX_POS = 48;
  localparam int unsigned QUADS   = 4;
  localparam int unsigned QSTEPS  = PIX_POS / QUADS;
  localparam int unsigned HALF    = PIX_POS / 2;
  localparam int unsigned LOC_W   = 6;
  localparam int unsigned QSEL_W  = $clog2(QUADS);
  localparam int unsigned OFF_W   = LOC_W - QSEL_W;
  localparam int unsigned NFIELD  = 6;

  typedef logic [LOC_W-1:0] loc_t;

  // field order, LSB first: reset-gate fall, transfer rise, ref strobe,
  // data strobe, data clock, output latch
  typedef struct packed {
    loc_t dout;
    loc_t dclk;
    loc_t shd;
    loc_t shp;
    loc_t h1r;
    loc_t rgf;
  } edge_cfg_t;
endpackage

// File: rtl/pix_loc_dec.sv
module pix_loc_dec
  import pix_edge_pkg::*;
(
  input  loc_t loc,
  output loc_t pos
);
  logic [QSEL_W-1:0] quad;
  logic [OFF_W-1:0]  off;
  logic [OFF_W-1:0]  off_sat;

  always_comb begin
    quad    = loc[LOC_W-1 -: QSEL_W];
    off     = loc[OFF_W-1:0];
    off_sat = (off > OFF_W'(QSTEPS - 1)) ? OFF_W'(QSTEPS - 1) : off;
    pos     = loc_t'(quad) * loc_t'(QSTEPS) + loc_t'(off_sat);
  end
endmodule

// File: rtl/pix_phase_ctr.sv
module pix_phase_ctr
  import pix_edge_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  output loc_t ph,
  output loc_t ph_nxt,
  output logic ph_last
);
  assign ph_last = (ph == loc_t'(PIX_POS - 1));
  assign ph_nxt  = ph_last ? '0 : ph + loc_t'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) ph <= '0;
    else        ph <= ph_nxt;
  end
endmodule

// File: rtl/pix_cfg_stage.sv
module pix_cfg_stage
  import pix_edge_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned WDATA_W   = 24,
  parameter int unsigned SMP_ADDR  = 2,
  parameter int unsigned EDGE_ADDR = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [WDATA_W-1:0] cfg_wdata,
  input  logic              ph_last,
  output edge_cfg_t         act_q,
  output edge_cfg_t         act_nxt
);
  localparam int unsigned SMP_BITS  = 4 * LOC_W;
  localparam int unsigned EDGE_BITS = 2 * LOC_W;

  edge_cfg_t shadow_q;
  logic      hit_smp, hit_edge;

  assign hit_smp  = cfg_we && (cfg_addr == ADDR_W'(SMP_ADDR));
  assign hit_edge = cfg_we && (cfg_addr == ADDR_W'(EDGE_ADDR));
  // live settings only move at the pixel boundary
  assign act_nxt  = ph_last ? shadow_q : act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= '0;
      act_q    <= '0;
    end else begin
      if (hit_smp)
        {shadow_q.dout, shadow_q.dclk, shadow_q.shd, shadow_q.shp} <= cfg_wdata[SMP_BITS-1:0];
      if (hit_edge)
        {shadow_q.h1r, shadow_q.rgf} <= cfg_wdata[EDGE_BITS-1:0];
      act_q <= act_nxt;
    end
  end
endmodule

// File: rtl/pix_wave_gen.sv
module pix_wave_gen
  import pix_edge_pkg::*;
#(
  parameter int unsigned DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  loc_t              ph_nxt,
  input  logic [NFIELD-1:0][LOC_W-1:0] pos_v,
  input  logic [DATA_W-1:0] din,
  output logic              rg_q,
  output logic              h1_q,
  output logic              h2_q,
  output logic              shp_q,
  output logic              shd_q,
  output logic              dclk_q,
  output logic [DATA_W-1:0] dout_q
);
  localparam int unsigned DW = LOC_W + 1;

  function automatic logic in_half(input loc_t p, input loc_t s);
    logic [DW-1:0] d;
    if (p >= s) d = DW'(p) - DW'(s);
    else        d = DW'(p) + DW'(PIX_POS) - DW'(s);
    return d < DW'(HALF);
  endfunction

  logic h1_win, cap_q;

  assign h1_win = in_half(ph_nxt, pos_v[1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rg_q   <= 1'b0;
      h1_q   <= 1'b1;
      h2_q   <= 1'b0;
      shp_q  <= 1'b1;
      shd_q  <= 1'b1;
      dclk_q <= 1'b1;
      cap_q  <= 1'b1;
      dout_q <= '0;
    end else begin
      rg_q   <= ph_nxt < pos_v[0];
      h1_q   <= h1_win;
      h2_q   <= !h1_win;
      shp_q  <= ph_nxt == pos_v[2];
      shd_q  <= ph_nxt == pos_v[3];
      dclk_q <= in_half(ph_nxt, pos_v[4]);
      cap_q  <= ph_nxt == pos_v[5];
      if (cap_q) dout_q <= din;
    end
  end
endmodule

// File: rtl/pix_edge_gen.sv
module pix_edge_gen
  import pix_edge_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned WDATA_W   = 24,
  parameter int unsigned DATA_W    = 10,
  parameter int unsigned SMP_ADDR  = 2,
  parameter int unsigned EDGE_ADDR = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [WDATA_W-1:0] cfg_wdata,
  input  logic [DATA_W-1:0]  pix_din,
  output logic               rgate,
  output logic               hclk_p,
  output logic               hclk_n,
  output logic               smp_ref,
  output logic               smp_dat,
  output logic               dclk,
  output logic [DATA_W-1:0]  pix_dout
);
  loc_t      ph, ph_nxt;
  logic      ph_last;
  edge_cfg_t act_q, act_nxt;
  logic [NFIELD-1:0][LOC_W-1:0] loc_v, pos_v;

  pix_phase_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .ph(ph), .ph_nxt(ph_nxt), .ph_last(ph_last)
  );

  pix_cfg_stage #(
    .ADDR_W(ADDR_W), .WDATA_W(WDATA_W), .SMP_ADDR(SMP_ADDR), .EDGE_ADDR(EDGE_ADDR)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ph_last(ph_last), .act_q(act_q), .act_nxt(act_nxt)
  );

  assign loc_v = act_nxt;

  for (genvar g = 0; g < NFIELD; g++) begin : g_dec
    pix_loc_dec u_dec (.loc(loc_v[g]), .pos(pos_v[g]));
  end

  pix_wave_gen #(.DATA_W(DATA_W)) u_wave (
    .clk(clk), .rst_n(rst_n), .ph_nxt(ph_nxt), .pos_v(pos_v), .din(pix_din),
    .rg_q(rgate), .h1_q(hclk_p), .h2_q(hclk_n), .shp_q(smp_ref),
    .shd_q(smp_dat), .dclk_q(dclk), .dout_q(pix_dout)
  );
endmodule

// File: rtl/pix_edge_gen_chk.sv
module pix_edge_gen_chk
  import pix_edge_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input loc_t      ph,
  input edge_cfg_t act,
  input logic      rg,
  input logic      h1,
  input logic      h2,
  input logic      shp,
  input logic      shd
);
  // R1
  ph_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph < loc_t'(PIX_POS));

  // R1
  ph_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == loc_t'(PIX_POS - 1)) |=> (ph == '0));

  // R3
  rg_rise_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rg) |-> (ph == '0));

  // R5
  h2_inverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h2 == !h1);

  // R6
  shp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shp |=> !shp);

  // R6
  shd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shd |=> !shd);

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != loc_t'(PIX_POS - 1)) |=> $stable(act));
endmodule

bind pix_edge_gen pix_edge_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ph(ph), .act(act_q),
  .rg(rgate), .h1(hclk_p), .h2(hclk_n), .shp(smp_ref), .shd(smp_dat)
);

// File: tb/pix_edge_gen_test.sv
module pix_edge_gen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_addr = '0;
  logic [23:0] cfg_wdata = '0;
  logic [9:0] pix_din = '0;
  logic rgate, hclk_p, hclk_n, smp_ref, smp_dat, dclk;
  logic [9:0] pix_dout;

  int tb_ph = 0;
  int pix = 0;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  pix_edge_gen uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pix_din(pix_din), .rgate(rgate), .hclk_p(hclk_p),
    .hclk_n(hclk_n), .smp_ref(smp_ref), .smp_dat(smp_dat), .dclk(dclk),
    .pix_dout(pix_dout)
  );

  // R1: the bench keeps its own position and pixel count
  always @(posedge clk) begin
    if (!rst_n) begin
      tb_ph <= 0;
      pix   <= 0;
    end else if (tb_ph == 47) begin
      tb_ph <= 0;
      pix   <= pix + 1;
    end else begin
      tb_ph <= tb_ph + 1;
    end
  end

  always @(negedge clk) pix_din <= {4'(pix), 6'(tb_ph)};

  // config vector: {dout, dclk, shd, shp, h1r, rgf}
  localparam logic [35:0] VEC [4] = '{
    {6'h10, 6'h00, 6'h1A, 6'h05, 6'h00, 6'h08},
    {6'h2F, 6'h23, 6'h3F, 6'h2B, 6'h21, 6'h30},
    {6'h3B, 6'h3B, 6'h0C, 6'h0E, 6'h3B, 6'h00},
    {6'h00, 6'h18, 6'h12, 6'h31, 6'h18, 6'h3B}
  };

  function automatic int dec(input logic [5:0] l);
    int o = int'(l[3:0]);
    if (o > 11) o = 11;
    return int'(l[5:4]) * 12 + o;
  endfunction

  function automatic logic [5:0] exp_wave(input int p, input logic [35:0] c);
    logic h1;
    h1 = ((p - dec(c[11:6]) + 48) % 48) < 24;
    return {p < dec(c[5:0]), h1, !h1, p == dec(c[17:12]), p == dec(c[23:18]),
            ((p - dec(c[29:24]) + 48) % 48) < 24};
  endfunction

  task automatic wait_ph(input int k);
    while (tb_ph != k) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [23:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic chk_pos(input logic [35:0] c, input bit chkd, input string tag);
    logic [5:0] e, a;
    logic [9:0] ed;
    int dp;
    e = exp_wave(tb_ph, c);
    a = {rgate, hclk_p, hclk_n, smp_ref, smp_dat, dclk};
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s pos %0d waves got %b exp %b", tag, tb_ph, a, e);
    end
    if (chkd) begin
      dp = dec(c[35:30]);
      ed = (tb_ph > dp) ? {4'(pix), 6'(dp)} : {4'(pix - 1), 6'(dp)};
      checks++;
      if (pix_dout !== ed) begin
        fails++;
        $display("FAIL R8 %s pos %0d dout got %h exp %h", tag, tb_ph, pix_dout, ed);
      end
    end
  endtask

  task automatic sweep(input logic [35:0] c, input int from, input bit chkd, input string tag);
    for (int p = from; p < 48; p++) begin
      wait_ph(p);
      chk_pos(c, chkd, tag);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [35:0] cur, nxt, mix;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R11: reset state, first position
    checks++;
    if ({rgate, hclk_p, hclk_n, smp_ref, smp_dat, dclk, pix_dout} !== {6'b010111, 10'h0}) begin
      fails++;
      $display("FAIL R11 reset outputs got %b_%h exp 010111_000",
               {rgate, hclk_p, hclk_n, smp_ref, smp_dat, dclk}, pix_dout);
    end
    sweep('0, 1, 0, "R11");

    // R2 R3 R4 R5 R6 R7 R8 table walk
    for (int i = 0; i < 4; i++) begin
      wait_ph(5);
      wr(8'd2, VEC[i][35:12]);
      wr(8'd3, {12'hA5C, VEC[i][11:0]});   // R10: upper bits ignored
      sweep(VEC[i], 0, 0, "R1 R2 R3 R4 R5 R6 R7 R10");
      sweep(VEC[i], 0, 1, "R1 R2 R3 R4 R5 R6 R7 R8");
    end

    // R9: mid-pixel write holds until the boundary
    cur = VEC[3];
    nxt = {cur[35:18], 6'h03, cur[11:6], 6'h14};
    wait_ph(20);
    wr(8'd3, {12'h000, nxt[11:0]});
    wr(8'd2, nxt[35:12]);
    sweep(cur, 22, 0, "R9 old");
    sweep(nxt, 0, 0, "R9 new");

    // R10: other addresses ignored
    wait_ph(3);
    wr(8'd5, 24'hFFFFFF);
    wr(8'd0, 24'hFFFFFF);
    wr(8'd1, 24'hFFFFFF);
    sweep(nxt, 6, 1, "R10");
    sweep(nxt, 0, 1, "R10");

    // R9: write at position 47 lands one pixel later
    mix = {VEC[0][35:12], nxt[11:0]};
    wait_ph(47);
    wr(8'd2, VEC[0][35:12]);
    sweep(nxt, 0, 1, "R9 late hold");
    sweep(mix, 0, 0, "R9 late apply");

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule